// File: doc/BRIEF.md
# Reset Cause Status Register

This block is a 16-bit status register that keeps a record of which event last reset the chip or put it into a low-power mode. Each source of a reset or mode change delivers a one-cycle pulse on its own input pin. That pulse sets a dedicated flag. Each flag also has its own list of hardware events that clear it. As a result, the flags that survive a brown-out, the one that survives everything except a power-on, and the watchdog flag that power-save entry and a watchdog kick wipe out each end up with the value boot firmware expects to read.

Software reads the whole register through a combinational read port. It writes through a plain 16-bit write strobe with no byte lanes. A written 1 only changes the stored bit: it never starts a reset. One unflagged bit is a plain read/write software watchdog enable. The block combines it with a configuration fuse to drive the effective watchdog enable. The register has no streaming data path, so every pin is a plain level or pulse with no handshake.

Top module: `rst_cause_reg`

## Requirements
- R1: While `rst_n` is low, the register reads 0x0001: only the power-on flag (bit 0) is set.
- R2: Each event pulse sets its own flag, visible on `rd_data` after the next rising clock edge. The bit positions are: trap 15, bad access 14, config mismatch 9, external pin 7, software reset 6, watchdog timeout 4, sleep 3, idle 2, brown-out 1, power-on 0.
- R3: The trap, bad access, external pin, software reset, sleep and idle flags clear on a power-on pulse or a brown-out pulse.
- R4: The config mismatch flag clears only on a power-on pulse and keeps its value across a brown-out.
- R5: The watchdog timeout flag clears on a sleep pulse, an idle pulse, a `wdog_clear` pulse, a power-on pulse or a brown-out pulse.
- R6: No hardware event clears the power-on flag or the brown-out flag.
- R7: When `wr_en` is high, every implemented bit takes the value of `wr_data` on the next edge. No other bit changes, and writing a 1 has no side effect. With no event and no write, the register holds its value.
- R8: If an event sets a flag in the same cycle that another event clears it, the flag ends at 1.
- R9: A hardware set or clear of a bit takes priority over a write in the same cycle. Bits that no event touches in that cycle still take the written value.
- R10: Bits 13..10 and 8 always read 0 and ignore writes. Bit 5 is the software watchdog enable, a plain read/write bit that resets to 0.
- R11: `wdog_enable` is 1 whenever `cfg_wdog_fuse` is 1. Otherwise it equals bit 5 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_trap_conflict | input | 1 | Trap conflict pulse |
| ev_bad_access | input | 1 | Illegal opcode or uninitialized register access pulse |
| ev_cfg_mismatch | input | 1 | Configuration mismatch pulse |
| ev_ext_pin | input | 1 | External reset pin pulse |
| ev_sw_reset | input | 1 | Software reset instruction pulse |
| ev_wdog_timeout | input | 1 | Watchdog time-out pulse |
| ev_sleep | input | 1 | Sleep entry pulse |
| ev_idle | input | 1 | Idle entry pulse |
| ev_brownout | input | 1 | Brown-out pulse |
| ev_power_on | input | 1 | Power-on pulse |
| wdog_clear | input | 1 | Watchdog-clear instruction pulse |
| cfg_wdog_fuse | input | 1 | Watchdog-always-on configuration fuse |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Register contents |
| wdog_enable | output | 1 | Effective watchdog enable |

## Verification
The bench covers several corner cases. The first is a brown-out with every flag set. A design that lumps the config mismatch flag in with the others loses it here, and one that lets brown-out clear its own flag reads 0 in bit 1. The second is a watchdog timeout that arrives together with idle entry: if clear beats set, the timeout goes unrecorded. The third is a power-on pulse that coincides with a write. A design that lets the write win shows the written watchdog bit, and one that applies the event to every bit drops the written brown-out value. The bench also writes all ones, which exposes a design that stores the unassigned bits, and it runs the fuse against the software bit to catch an enable that ignores either one.

// File: rtl/rcr_pkg.sv
package rcr_pkg;

  localparam int unsigned REG_W = 16;

  // flag bit positions (software decodes these)
  localparam int unsigned B_TRAP   = 15;
  localparam int unsigned B_BADACC = 14;
  localparam int unsigned B_CFGMIS = 9;
  localparam int unsigned B_EXTPIN = 7;
  localparam int unsigned B_SWRST  = 6;
  localparam int unsigned B_WDEN   = 5;
  localparam int unsigned B_WDTO   = 4;
  localparam int unsigned B_SLEEP  = 3;
  localparam int unsigned B_IDLE   = 2;
  localparam int unsigned B_BROWN  = 1;
  localparam int unsigned B_PWRON  = 0;

  localparam logic [REG_W-1:0] FLAG_MASK = REG_W'(
      (1 << B_TRAP) | (1 << B_BADACC) | (1 << B_CFGMIS) | (1 << B_EXTPIN) |
      (1 << B_SWRST) | (1 << B_WDTO) | (1 << B_SLEEP) | (1 << B_IDLE) |
      (1 << B_BROWN) | (1 << B_PWRON));

  localparam logic [REG_W-1:0] IMPL_MASK = FLAG_MASK | REG_W'(1 << B_WDEN);

  localparam logic [REG_W-1:0] RESET_VAL = REG_W'(1 << B_PWRON);

  typedef enum logic [1:0] {
    CLR_NONE,     // no hardware clear
    CLR_POR,      // power-on only
    CLR_POR_BOR,  // power-on or brown-out
    CLR_WDOG      // power-save, watchdog kick, power-on, brown-out
  } clr_class_e;

  function automatic clr_class_e clr_class(int unsigned b);
    if (b == B_CFGMIS) return CLR_POR;
    if (b == B_WDTO) return CLR_WDOG;
    if (b == B_TRAP || b == B_BADACC || b == B_EXTPIN || b == B_SWRST ||
        b == B_SLEEP || b == B_IDLE) return CLR_POR_BOR;
    return CLR_NONE;
  endfunction

endpackage

// File: rtl/rcr_evt_map.sv
module rcr_evt_map
  import rcr_pkg::*;
(
  input  logic             ev_trap_conflict,
  input  logic             ev_bad_access,
  input  logic             ev_cfg_mismatch,
  input  logic             ev_ext_pin,
  input  logic             ev_sw_reset,
  input  logic             ev_wdog_timeout,
  input  logic             ev_sleep,
  input  logic             ev_idle,
  input  logic             ev_brownout,
  input  logic             ev_power_on,
  input  logic             wdog_clear,
  output logic [REG_W-1:0] set_v,
  output logic [REG_W-1:0] clr_v
);

  logic clr_por, clr_por_bor, clr_wdog;

  assign clr_por     = ev_power_on;
  assign clr_por_bor = ev_power_on | ev_brownout;
  assign clr_wdog    = clr_por_bor | ev_sleep | ev_idle | wdog_clear;

  always_comb begin
    set_v           = '0;
    set_v[B_TRAP]   = ev_trap_conflict;
    set_v[B_BADACC] = ev_bad_access;
    set_v[B_CFGMIS] = ev_cfg_mismatch;
    set_v[B_EXTPIN] = ev_ext_pin;
    set_v[B_SWRST]  = ev_sw_reset;
    set_v[B_WDTO]   = ev_wdog_timeout;
    set_v[B_SLEEP]  = ev_sleep;
    set_v[B_IDLE]   = ev_idle;
    set_v[B_BROWN]  = ev_brownout;
    set_v[B_PWRON]  = ev_power_on;
  end

  for (genvar b = 0; b < REG_W; b++) begin : g_clr
    localparam clr_class_e CC = clr_class(b);
    if (CC == CLR_POR) begin : g_por
      assign clr_v[b] = clr_por;
    end else if (CC == CLR_POR_BOR) begin : g_porbor
      assign clr_v[b] = clr_por_bor;
    end else if (CC == CLR_WDOG) begin : g_wd
      assign clr_v[b] = clr_wdog;
    end else begin : g_none
      assign clr_v[b] = 1'b0;
    end
  end

endmodule

// File: rtl/rcr_flag_cell.sv
module rcr_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wr_i,
  input  logic wd_i,
  output logic q_o
);

  // priority: hardware set, then hardware clear, then software write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= RST_VAL;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
    else if (wr_i)  q_o <= wd_i;
  end

  // R2 R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R9
  clr_beats_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R7
  write_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !set_i && !clr_i) |=> (q_o == $past(wd_i)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !set_i && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_trap_conflict,
  input  logic             ev_bad_access,
  input  logic             ev_cfg_mismatch,
  input  logic             ev_ext_pin,
  input  logic             ev_sw_reset,
  input  logic             ev_wdog_timeout,
  input  logic             ev_sleep,
  input  logic             ev_idle,
  input  logic             ev_brownout,
  input  logic             ev_power_on,
  input  logic             wdog_clear,
  input  logic             cfg_wdog_fuse,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             wdog_enable
);

  logic [REG_W-1:0] set_v, clr_v, bits_q;

  rcr_evt_map u_map (
    .ev_trap_conflict (ev_trap_conflict),
    .ev_bad_access    (ev_bad_access),
    .ev_cfg_mismatch  (ev_cfg_mismatch),
    .ev_ext_pin       (ev_ext_pin),
    .ev_sw_reset      (ev_sw_reset),
    .ev_wdog_timeout  (ev_wdog_timeout),
    .ev_sleep         (ev_sleep),
    .ev_idle          (ev_idle),
    .ev_brownout      (ev_brownout),
    .ev_power_on      (ev_power_on),
    .wdog_clear       (wdog_clear),
    .set_v            (set_v),
    .clr_v            (clr_v)
  );

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (IMPL_MASK[b]) begin : g_cell
      rcr_flag_cell #(.RST_VAL(RESET_VAL[b])) u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v[b]),
        .clr_i (clr_v[b]),
        .wr_i  (wr_en),
        .wd_i  (wr_data[b]),
        .q_o   (bits_q[b])
      );
    end else begin : g_zero
      assign bits_q[b] = 1'b0;
    end
  end

  assign rd_data     = bits_q;
  assign wdog_enable = cfg_wdog_fuse | bits_q[B_WDEN];

  // R11
  fuse_forces_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wdog_fuse |-> wdog_enable);

  // R11
  soft_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wdog_fuse |-> (wdog_enable == rd_data[B_WDEN]));

  // R4
  cfg_survives_bor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_brownout && !ev_power_on && rd_data[B_CFGMIS]) |=> rd_data[B_CFGMIS]);

  // R6
  bor_flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_BROWN] && !wr_en) |=> rd_data[B_BROWN]);

endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  evt = '0;  // [9]trap [8]badacc [7]cfg [6]pin [5]swrst [4]wdto [3]sleep [2]idle [1]brown [0]pwron
  logic        wdc = 1'b0;
  logic        fuse = 1'b0;
  logic        wr = 1'b0;
  logic [15:0] wd = '0;
  logic [15:0] rd;
  logic        wen;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rst_cause_reg u_dut (
    .clk (clk), .rst_n (rst_n),
    .ev_trap_conflict (evt[9]), .ev_bad_access (evt[8]),
    .ev_cfg_mismatch (evt[7]), .ev_ext_pin (evt[6]),
    .ev_sw_reset (evt[5]), .ev_wdog_timeout (evt[4]),
    .ev_sleep (evt[3]), .ev_idle (evt[2]),
    .ev_brownout (evt[1]), .ev_power_on (evt[0]),
    .wdog_clear (wdc), .cfg_wdog_fuse (fuse),
    .wr_en (wr), .wr_data (wd),
    .rd_data (rd), .wdog_enable (wen)
  );

  // {req[3:0], evt[9:0], wdc, wr, wdata[15:0], expected[15:0]}
  localparam int NV = 19;
  localparam logic [47:0] VEC [NV] = '{
    {4'd7,  10'b0000000000, 1'b0, 1'b1, 16'h0000, 16'h0000}, // R7 clear all
    {4'd2,  10'b1000000000, 1'b0, 1'b0, 16'h0000, 16'h8000}, // R2 trap
    {4'd2,  10'b0110000000, 1'b0, 1'b0, 16'h0000, 16'hC200}, // R2 badacc+cfg
    {4'd2,  10'b0001110000, 1'b0, 1'b0, 16'h0000, 16'hC2D0}, // R2 pin,sw,wdto
    {4'd4,  10'b0000000010, 1'b0, 1'b0, 16'h0000, 16'h0202}, // R4 R3 brown-out
    {4'd2,  10'b0000010000, 1'b0, 1'b0, 16'h0000, 16'h0212}, // R2 wdto
    {4'd5,  10'b0000000000, 1'b1, 1'b0, 16'h0000, 16'h0202}, // R5 kick
    {4'd2,  10'b0000010000, 1'b0, 1'b0, 16'h0000, 16'h0212}, // R2 wdto
    {4'd5,  10'b0000001000, 1'b0, 1'b0, 16'h0000, 16'h020A}, // R5 sleep
    {4'd8,  10'b0000010100, 1'b0, 1'b0, 16'h0000, 16'h021E}, // R8 wdto+idle
    {4'd6,  10'b0000000001, 1'b0, 1'b0, 16'h0000, 16'h0003}, // R6 R3 power-on
    {4'd10, 10'b0000000000, 1'b0, 1'b1, 16'hFFFF, 16'hC2FF}, // R10 all ones
    {4'd9,  10'b0010000000, 1'b0, 1'b1, 16'h0000, 16'h0200}, // R9 cfg vs write
    {4'd8,  10'b0010000001, 1'b0, 1'b0, 16'h0000, 16'h0201}, // R8 cfg+pwron
    {4'd7,  10'b0000000000, 1'b0, 1'b0, 16'h0000, 16'h0201}, // R7 hold
    {4'd7,  10'b0000000000, 1'b0, 1'b1, 16'h0002, 16'h0002}, // R7 write one
    {4'd2,  10'b0000000100, 1'b0, 1'b0, 16'h0000, 16'h0006}, // R2 idle
    {4'd3,  10'b0000000010, 1'b0, 1'b0, 16'h0000, 16'h0002}, // R3 brown-out
    {4'd9,  10'b1000000001, 1'b0, 1'b1, 16'h0010, 16'h8001}  // R9 pwron+trap vs write
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] e, input logic k, input logic w, input logic [15:0] d);
    @(negedge clk);
    evt = e; wdc = k; wr = w; wd = d;
    @(negedge clk);
    evt = '0; wdc = 1'b0; wr = 1'b0; wd = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset value", rd, 16'h0001);
    check("R11 enable off", {15'd0, wen}, 16'h0001 ^ 16'h0001);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][43:34], VEC[i][33], VEC[i][32], VEC[i][31:16]);
      check($sformatf("R%0d row %0d", VEC[i][47:44], i), rd, VEC[i][15:0]);
    end

    // R11 fuse forces enable with software bit 0
    step(10'b0, 1'b0, 1'b1, 16'h0000);
    fuse = 1'b1; #1;
    check("R11 fuse on", {15'd0, wen}, 16'h0001);
    fuse = 1'b0; #1;
    check("R11 fuse off, sw 0", {15'd0, wen}, 16'h0000);
    // R10 software enable bit is read/write
    step(10'b0, 1'b0, 1'b1, 16'h0020);
    check("R10 sw enable bit", rd, 16'h0020);
    check("R11 sw enable drives", {15'd0, wen}, 16'h0001);
    // R1 reset mid-run
    step(10'b0, 1'b0, 1'b1, 16'hFFFF);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset after write", rd, 16'h0001);
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule